// File: doc/BRIEF.md
# I2C Register-Access Target

This block is a serial-bus target that lets an I2C host read and write a small bank of eight-bit configuration registers. It samples the bus clock and data lines through two-flop synchronizers, detects START, repeated START and STOP, and answers only to one hard-wired 7-bit device address. SDA is driven solely as an open-drain pull-down through an output-enable. The current register contents are presented on a flat parallel output so the rest of the chip can use them directly.

A write frame carries the device address with R/W low, then a pointer byte that selects a register, then any number of data bytes. A read frame, usually reached through a repeated START after a pointer write, returns registers starting at the current pointer. The pointer advances by one after every data byte in either direction and wraps from the last register to register 0. A host that does not acknowledge a read byte ends the read, and the target lets go of SDA.

Top module: `i2c_regs_target`

## Requirements
- R1: After reset the pointer is 0, every register reads 0 and `sda_oe` is 0 (SDA released).
- R2: The address byte (MSB first, R/W in bit 0) matching 7'b1000000 is acknowledged: 0x80 opens a write, 0x81 a read. An acknowledge holds SDA low for the whole ninth clock high phase.
- R3: A non-matching address byte is not acknowledged, and every later byte of that frame is ignored (no acknowledge, no register change) until the next START or STOP.
- R4: In a write frame the first byte after the address loads the pointer from its low four bits and is acknowledged.
- R5: Each further byte of a write frame is stored in the register selected by the pointer, is acknowledged, and advances the pointer by one.
- R6: The pointer wraps from 15 to 0, for writes and for reads.
- R7: A read frame returns the register at the pointer, MSB first, and advances the pointer after each byte sent; a pointer write followed by a repeated START and a read returns data from the written pointer.
- R8: A host acknowledge after a read byte makes the target send the next register; a host not-acknowledge makes it release SDA and drive nothing until the next START.
- R9: A STOP or repeated START at any bit position abandons the byte in progress without writing it and keeps the pointer value for the next frame.
- R10: `sda_oe` changes only while the synchronized SCL is low.
- R11: `regs_q[8n+7:8n]` always shows register n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_q | output | 128 | All registers, register n at bits 8n+7:8n |

## Verification
Assertions check on every cycle that SDA is released in idle and while the host acknowledges, that an acknowledge from the target stays asserted across the whole high phase of the ninth clock, that the output enable only rises while SCL is low, that START and STOP force the state machine back to address reception or idle, and that the pointer wraps to zero. Address matching, pointer loading, stored data, the values returned by reads, pointer retention across aborted frames and the silence after a wrong address can only be shown by the bench's frames, which compare the register outputs against a behavioural model on every clock and check every acknowledge and read byte.

// File: rtl/i2c_regs_target.sv
module i2c_regs_target #(
  parameter logic [6:0] DEV_ADDR = 7'b1000000,
  parameter int         NREG     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [8*NREG-1:0] regs_q
);
  localparam int PW = $clog2(NREG);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RACK, S_TX, S_TACK} st_t;
  typedef enum logic [1:0] {K_ADDR, K_PTR, K_DATA} kind_t;

  logic [2:0]    scl_s, sda_s;
  st_t           st;
  kind_t         kind;
  logic [3:0]    cnt;
  logic [7:0]    sh;
  logic [PW-1:0] ptr;
  logic          rw, mack;
  logic [7:0]    regs [NREG];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= '1;
      sda_s <= '1;
    end else begin
      scl_s <= {scl_s[1:0], scl_i};
      sda_s <= {sda_s[1:0], sda_i};
    end

  wire scl       = scl_s[1];
  wire scl_d     = scl_s[2];
  wire sda       = sda_s[1];
  wire sda_d     = sda_s[2];
  wire scl_rise  = scl & ~scl_d;
  wire scl_fall  = ~scl & scl_d;
  wire start_det = scl & scl_d & sda_d & ~sda;
  wire stop_det  = scl & scl_d & ~sda_d & sda;

  wire [PW-1:0] ptr_nxt = (ptr == PW'(NREG - 1)) ? '0 : ptr + 1'b1;
  wire [7:0]    rdata   = regs[ptr];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= S_IDLE;
      kind   <= K_ADDR;
      cnt    <= '0;
      sh     <= '0;
      ptr    <= '0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (stop_det) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      st     <= S_RX;
      kind   <= K_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        S_RX:
          if (scl_rise && cnt != 4'd8) begin
            sh  <= {sh[6:0], sda};
            cnt <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            cnt <= '0;
            if (kind == K_ADDR) begin
              if (sh[7:1] == DEV_ADDR) begin
                rw     <= sh[0];
                st     <= S_RACK;
                sda_oe <= 1'b1;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              st     <= S_RACK;
              sda_oe <= 1'b1;
              if (kind == K_PTR) ptr <= sh[PW-1:0];
              else begin
                regs[ptr] <= sh;
                ptr       <= ptr_nxt;
              end
            end
          end
        S_RACK:
          if (scl_fall) begin
            if (kind == K_ADDR && rw) begin
              st     <= S_TX;
              sh     <= {rdata[6:0], 1'b0};
              sda_oe <= ~rdata[7];
            end else begin
              st     <= S_RX;
              sda_oe <= 1'b0;
              kind   <= (kind == K_ADDR) ? K_PTR : K_DATA;
            end
          end
        S_TX:
          if (scl_rise) cnt <= cnt + 4'd1;
          else if (scl_fall) begin
            if (cnt == 4'd8) begin
              st     <= S_TACK;
              sda_oe <= 1'b0;
              cnt    <= '0;
              ptr    <= ptr_nxt;
            end else begin
              sda_oe <= ~sh[7];
              sh     <= {sh[6:0], 1'b0};
            end
          end
        S_TACK:
          if (scl_rise) mack <= ~sda;
          else if (scl_fall) begin
            if (mack) begin
              st     <= S_TX;
              sh     <= {rdata[6:0], 1'b0};
              sda_oe <= ~rdata[7];
            end else begin
              st <= S_IDLE;
            end
          end
        default: st <= S_IDLE;
      endcase
    end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_q[8*g +: 8] = regs[g];
  end

  // R10
  oe_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(!scl));
  // R2
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RACK && scl) |-> sda_oe);
  // R8
  tack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TACK || st == S_IDLE) |-> !sda_oe);
  // R9
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> (st == S_RX && kind == K_ADDR && cnt == 4'd0));
  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == S_IDLE && !sda_oe && $stable(ptr)));
  // R6
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ptr) == PW'(NREG - 1) && ptr != $past(ptr) && $past(st) != S_RX) |-> ptr == '0);
endmodule

// File: tb/tb_i2c_regs_target.sv
module tb_i2c_regs_target;
  localparam int CLK_PER = 10;
  localparam int H       = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [127:0] regs_q;
  wire  sda_line = sda_m & ~sda_oe;

  i2c_regs_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .regs_q(regs_q)
  );

  always #(CLK_PER/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [7:0] mdl [16];
  logic cmp_en = 1'b0;
  logic oe_prev = 1'b0;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // R11 / R5: register outputs against the model on every clock between frames
  always @(negedge clk) begin
    if (cmp_en) begin
      checks++;
      for (int i = 0; i < 16; i++)
        if (regs_q[8*i +: 8] !== mdl[i]) begin
          errors++;
          $display("FAIL R11 reg %0d actual=%0h expected=%0h", i, regs_q[8*i +: 8], mdl[i]);
          break;
        end
    end
    // R10: output enable may only move while the bus clock is low
    if (rst_n && sda_oe !== oe_prev) begin
      checks++;
      if (scl_m) begin
        errors++;
        $display("FAIL R10 sda_oe changed with scl high actual=%0b expected=%0b", sda_oe, oe_prev);
      end
    end
    oe_prev = sda_oe;
  end

  task automatic hwait(); repeat (H) @(negedge clk); endtask

  task automatic bstart();
    cmp_en = 1'b0;
    sda_m = 1'b1; scl_m = 1'b1; hwait();
    sda_m = 1'b0; hwait();
    scl_m = 1'b0; hwait();
  endtask

  task automatic brestart();
    sda_m = 1'b1; hwait();
    scl_m = 1'b1; hwait();
    sda_m = 1'b0; hwait();
    scl_m = 1'b0; hwait();
  endtask

  task automatic bstop();
    sda_m = 1'b0; hwait();
    scl_m = 1'b1; hwait();
    sda_m = 1'b1; hwait();
    hwait();
    cmp_en = 1'b1;
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; hwait();
      scl_m = 1'b1; hwait();
      scl_m = 1'b0;
    end
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    logic a0, a1;
    send_bits(b, 8);
    sda_m = 1'b1; hwait();
    scl_m = 1'b1;
    repeat (2) @(negedge clk);
    a0 = sda_line;
    repeat (H - 3) @(negedge clk);
    a1 = sda_line;
    @(negedge clk);
    scl_m = 1'b0;
    ack = !a0 && !a1;
  endtask

  task automatic rbyte(input logic host_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hwait();
      scl_m = 1'b1;
      repeat (H/2) @(negedge clk);
      b[i] = sda_line;
      repeat (H - H/2) @(negedge clk);
      scl_m = 1'b0;
    end
    sda_m = !host_ack; hwait();
    scl_m = 1'b1; hwait();
    scl_m = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk("R1 sda_oe", {31'b0, sda_oe}, 0);
    chk("R1 regs", {31'b0, regs_q == '0}, 1);
    cmp_en = 1'b1;
    hwait();

    // R1: read with the reset pointer returns register 0
    bstart();
    wbyte(8'h81, a); chk("R1 read addr ack", {31'b0, a}, 1);
    rbyte(1'b0, d);  chk("R1 reg0 at reset ptr", {24'b0, d}, 0);
    bstop();

    // R2, R4, R5: write pointer 2, then four data bytes
    bstart();
    wbyte(8'h80, a); chk("R2 write addr ack", {31'b0, a}, 1);
    wbyte(8'h02, a); chk("R4 pointer ack", {31'b0, a}, 1);
    wbyte(8'hA5, a); chk("R5 data ack", {31'b0, a}, 1);
    wbyte(8'h3C, a); chk("R5 data ack", {31'b0, a}, 1);
    wbyte(8'h96, a); chk("R5 data ack", {31'b0, a}, 1);
    wbyte(8'hC3, a); chk("R5 data ack", {31'b0, a}, 1);
    bstop();
    mdl[2] = 8'hA5; mdl[3] = 8'h3C; mdl[4] = 8'h96; mdl[5] = 8'hC3;
    hwait();

    // R3: wrong address, later bytes ignored
    bstart();
    wbyte(8'h42, a); chk("R3 wrong addr nack", {31'b0, a}, 0);
    wbyte(8'h03, a); chk("R3 ignored byte nack", {31'b0, a}, 0);
    wbyte(8'hFF, a); chk("R3 ignored byte nack", {31'b0, a}, 0);
    bstop();
    chk("R3 reg3 kept", {24'b0, regs_q[8*3 +: 8]}, 32'h3C);

    // R7, R8: combined pointer write, repeated START, read
    bstart();
    wbyte(8'h80, a); chk("R7 addr ack", {31'b0, a}, 1);
    wbyte(8'h02, a); chk("R7 pointer ack", {31'b0, a}, 1);
    brestart();
    wbyte(8'h81, a); chk("R2 read addr ack", {31'b0, a}, 1);
    rbyte(1'b1, d);  chk("R7 read byte0", {24'b0, d}, 32'hA5);
    rbyte(1'b1, d);  chk("R8 read after ack", {24'b0, d}, 32'h3C);
    rbyte(1'b0, d);  chk("R7 read byte2", {24'b0, d}, 32'h96);
    repeat (2*H) @(negedge clk);
    chk("R8 released after nack", {31'b0, sda_oe}, 0);
    bstop();

    // R9: pointer kept across STOP (now 5)
    bstart();
    wbyte(8'h81, a); chk("R9 addr ack", {31'b0, a}, 1);
    rbyte(1'b0, d);  chk("R9 pointer kept", {24'b0, d}, 32'hC3);
    bstop();

    // R6: write wrap from 15 to 0
    bstart();
    wbyte(8'h80, a);
    wbyte(8'h0F, a); chk("R6 pointer ack", {31'b0, a}, 1);
    wbyte(8'h11, a); chk("R6 data ack", {31'b0, a}, 1);
    wbyte(8'h22, a); chk("R6 wrapped data ack", {31'b0, a}, 1);
    bstop();
    mdl[15] = 8'h11; mdl[0] = 8'h22;

    // R6: read wrap
    bstart();
    wbyte(8'h80, a);
    wbyte(8'h0F, a);
    brestart();
    wbyte(8'h81, a);
    rbyte(1'b1, d); chk("R6 read reg15", {24'b0, d}, 32'h11);
    rbyte(1'b0, d); chk("R6 read wraps to reg0", {24'b0, d}, 32'h22);
    bstop();

    // R9: partial byte then repeated START, pointer kept at 3
    bstart();
    wbyte(8'h80, a);
    wbyte(8'h03, a);
    send_bits(8'hEE, 5);
    brestart();
    wbyte(8'h81, a); chk("R9 addr after restart", {31'b0, a}, 1);
    rbyte(1'b0, d);  chk("R9 partial byte dropped", {24'b0, d}, 32'h3C);
    bstop();

    // R9: partial byte then STOP
    bstart();
    wbyte(8'h80, a);
    wbyte(8'h08, a);
    send_bits(8'h5A, 4);
    bstop();
    chk("R9 reg8 untouched", {24'b0, regs_q[8*8 +: 8]}, 0);
    bstart();
    wbyte(8'h81, a);
    rbyte(1'b0, d); chk("R9 pointer 8 kept", {24'b0, d}, 0);
    bstop();
    bstart();
    wbyte(8'h81, a);
    rbyte(1'b0, d); chk("R9 pointer advanced to 9", {24'b0, d}, 0);
    bstop();

    repeat (20) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule